// File: doc/BRIEF.md
# Processor exception entry unit

This block sits at the commit end of a 32-bit pipeline and turns pending fault requests into a taken exception. Each cycle it looks at a vector of request lines, one per fault kind, together with the faulting virtual address, a store/load flag, the offending coprocessor number and the faulting virtual page number. It picks one request by fixed priority and works out the 5-bit exception code. It then forms the handler address as a base plus a per-fault offset.

On the clock edge that takes a fault, the unit updates its control state. This covers the exception level bit, the cause code, the coprocessor-error field, the bad-address register and the page field of the context register. One cycle later it emits a single-cycle redirect pulse carrying the handler address. A reset request redirects to the fixed boot address and enables coprocessor 1. Soft reset and non-maskable interrupt are accepted but only raise an unimplemented flag.

A narrow configuration input loads the bootstrap-vector select, the interrupt-vector select and the exception base. A return input clears the exception level. The state is visible on read outputs.

Top module: `exc_entry_unit`

## Requirements
- R1: After `rst_ni` is asserted, the outputs read: `status_exl_o`=0, `status_bev_o`=1, `cause_iv_o`=0, `ebase_o`=0x80000000, `status_cu1_o`=0, `exc_code_o`=0, `cause_ce_o`=0, `bad_vaddr_o`=0, `ctx_badvpn2_o`=0, `redirect_o`=0 and `unimpl_o`=0.
- R2: `req_i` bit positions are: 0 reset, 1 NMI, 2 soft reset, 3 machine check, 4 address error, 5 TLB refill, 6 TLB invalid, 7 TLB modified, 8 syscall, 9 breakpoint, 10 reserved instruction, 11 coprocessor unusable, 12 overflow, 13 trap, 14 interrupt. When several bits are set, the lowest set bit alone is taken, and exactly one fault is taken per cycle.
- R3: The code written to `exc_code_o` (Cause bits 6:2) depends on the fault kind:
  - interrupt 0, TLB modified 1;
  - TLB refill and TLB invalid give 3 when `is_store_i`=1 and 2 otherwise;
  - address error gives 5 for a store and 4 for a load;
  - syscall 8, breakpoint 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, machine check 24.
- R4: The handler base is 0xBFC00200 when BEV is 1 and the exception base register when BEV is 0, using the values held before the edge.
- R5: The handler offset is 0x180 for every taken fault except two:
  - an interrupt uses 0x200 when IV is 1 and 0x000 when IV is 0;
  - a TLB refill uses 0x000 when EXL was 0 before the edge and 0x180 when EXL was already 1.
- R6: The cycle after an edge that takes a redirecting request, `redirect_o` is 1 for exactly that cycle and `redirect_pc_o` holds the target. With no request pending, `redirect_o` and `unimpl_o` are 0 the next cycle.
- R7: A taken fault from bit 3 up to bit 14 sets EXL and writes `exc_code_o`. With no such fault, `eret_i` clears EXL, and otherwise EXL holds.
- R8: Address-error and TLB faults (bits 4 to 7) load `bad_vaddr_o` from `bad_addr_i`. Other requests leave it unchanged.
- R9: TLB faults (bits 5 to 7) load `ctx_badvpn2_o` with `vpn_i` shifted right by 2. Other requests leave it unchanged.
- R10: A coprocessor-unusable fault loads `cause_ce_o` from `cop_id_i`. Other requests leave it unchanged.
- R11: A taken reset request redirects to 0xBFC00000 and sets `status_cu1_o`. It leaves EXL (apart from `eret_i`), the code, CE, BadVAddr and Context unchanged.
- R12: A taken NMI or soft reset request pulses `unimpl_o` for one cycle. It does not redirect and changes no state other than an `eret_i` clear of EXL.
- R13: When `cfg_we_i` is 1, it loads BEV, IV and the exception base from `cfg_bev_i`, `cfg_iv_i` and `cfg_ebase_i`. A fault taken at the same edge uses the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 15 | Pending fault request lines, one per kind |
| is_store_i | input | 1 | Faulting access was a store |
| bad_addr_i | input | 32 | Faulting virtual address |
| vpn_i | input | 21 | Faulting virtual page number |
| cop_id_i | input | 2 | Offending coprocessor number |
| eret_i | input | 1 | Clear the exception level |
| cfg_we_i | input | 1 | Load BEV, IV and exception base |
| cfg_bev_i | input | 1 | New bootstrap-vector select |
| cfg_iv_i | input | 1 | New interrupt-vector select |
| cfg_ebase_i | input | 32 | New exception base |
| redirect_o | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc_o | output | 32 | Handler address for the redirect |
| unimpl_o | output | 1 | One-cycle pulse for NMI or soft reset |
| exc_code_o | output | 5 | Cause exception-code field |
| cause_ce_o | output | 2 | Cause coprocessor-error field |
| cause_iv_o | output | 1 | Interrupt-vector select |
| bad_vaddr_o | output | 32 | Bad virtual address register |
| ctx_badvpn2_o | output | 19 | Context page field |
| status_exl_o | output | 1 | Exception level |
| status_bev_o | output | 1 | Bootstrap-vector select |
| status_cu1_o | output | 1 | Coprocessor 1 usable |
| ebase_o | output | 32 | Exception base register |

## Verification
The first sweep drives every request line alone under all sixteen combinations of BEV, IV, prior EXL and store flag. This separates the offset choices for interrupt and TLB refill, the load/store code split and the base choice. A second sweep drives every pair of request lines, which exposes any error in the priority order. Pseudo-random multi-bit vectors with random configuration writes, returns and back-to-back requests then check that side effects stay confined to their own fault kinds. They also check that configuration written at the same edge as a fault does not leak into that fault's handler address.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int NUM_REQ   = 15;
  localparam int REQ_IDX_W = $clog2(NUM_REQ);
  localparam int CODE_W    = 5;

  // request line positions, lowest index has highest priority
  localparam int F_RESET      = 0;
  localparam int F_NMI        = 1;
  localparam int F_SRST       = 2;
  localparam int F_MCHK       = 3;
  localparam int F_ADDR       = 4;
  localparam int F_TLB_REFILL = 5;
  localparam int F_TLB_INVAL  = 6;
  localparam int F_TLB_MOD    = 7;
  localparam int F_SYSCALL    = 8;
  localparam int F_BREAK      = 9;
  localparam int F_RSVD       = 10;
  localparam int F_COPU       = 11;
  localparam int F_OVF        = 12;
  localparam int F_TRAP       = 13;
  localparam int F_INTR       = 14;

  localparam logic [CODE_W-1:0] EC_INT   = 5'd0;
  localparam logic [CODE_W-1:0] EC_MOD   = 5'd1;
  localparam logic [CODE_W-1:0] EC_TLBL  = 5'd2;
  localparam logic [CODE_W-1:0] EC_TLBS  = 5'd3;
  localparam logic [CODE_W-1:0] EC_ADEL  = 5'd4;
  localparam logic [CODE_W-1:0] EC_ADES  = 5'd5;
  localparam logic [CODE_W-1:0] EC_SYS   = 5'd8;
  localparam logic [CODE_W-1:0] EC_BP    = 5'd9;
  localparam logic [CODE_W-1:0] EC_RI    = 5'd10;
  localparam logic [CODE_W-1:0] EC_CPU   = 5'd11;
  localparam logic [CODE_W-1:0] EC_OV    = 5'd12;
  localparam logic [CODE_W-1:0] EC_TR    = 5'd13;
  localparam logic [CODE_W-1:0] EC_MCHK  = 5'd24;

  typedef enum logic [1:0] {
    OFS_GENERAL,
    OFS_INTR,
    OFS_REFILL
  } ofs_sel_e;

  typedef struct packed {
    logic              taken;     // vectored fault, sets EXL
    logic              to_reset;  // reset request
    logic              unimpl;    // NMI or soft reset
    logic [CODE_W-1:0] code;
    ofs_sel_e          ofs;
    logic              wr_bad;
    logic              wr_ctx;
    logic              wr_ce;
  } exc_dec_t;
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
  parameter int N  = 15,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | req_i[i];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/exc_decode.sv
module exc_decode
  import exc_entry_pkg::*;
(
  input  logic [REQ_IDX_W-1:0] idx_i,
  input  logic                 any_i,
  input  logic                 is_store_i,
  output exc_dec_t             dec_o
);
  always_comb begin
    dec_o        = '0;
    dec_o.ofs    = OFS_GENERAL;
    dec_o.taken  = any_i;
    case (int'(idx_i))
      F_RESET: begin
        dec_o.taken    = 1'b0;
        dec_o.to_reset = any_i;
      end
      F_NMI, F_SRST: begin
        dec_o.taken  = 1'b0;
        dec_o.unimpl = any_i;
      end
      F_MCHK: dec_o.code = EC_MCHK;
      F_ADDR: begin
        dec_o.code   = is_store_i ? EC_ADES : EC_ADEL;
        dec_o.wr_bad = 1'b1;
      end
      F_TLB_REFILL, F_TLB_INVAL: begin
        dec_o.code   = is_store_i ? EC_TLBS : EC_TLBL;
        dec_o.wr_bad = 1'b1;
        dec_o.wr_ctx = 1'b1;
        if (int'(idx_i) == F_TLB_REFILL) dec_o.ofs = OFS_REFILL;
      end
      F_TLB_MOD: begin
        dec_o.code   = EC_MOD;
        dec_o.wr_bad = 1'b1;
        dec_o.wr_ctx = 1'b1;
      end
      F_SYSCALL: dec_o.code = EC_SYS;
      F_BREAK:   dec_o.code = EC_BP;
      F_RSVD:    dec_o.code = EC_RI;
      F_COPU: begin
        dec_o.code  = EC_CPU;
        dec_o.wr_ce = 1'b1;
      end
      F_OVF:  dec_o.code = EC_OV;
      F_TRAP: dec_o.code = EC_TR;
      F_INTR: begin
        dec_o.code = EC_INT;
        dec_o.ofs  = OFS_INTR;
      end
      default: dec_o = '0;
    endcase
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_entry_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_PC  = 32'hBFC0_0000,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 32'hBFC0_0200,
  parameter int                OFS_GEN   = 'h180,
  parameter int                OFS_IVEC  = 'h200
) (
  input  exc_dec_t          dec_i,
  input  logic              bev_i,
  input  logic              iv_i,
  input  logic              exl_i,
  input  logic [ADDR_W-1:0] ebase_i,
  output logic [ADDR_W-1:0] pc_o
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] ofs;

  assign base = bev_i ? BOOT_BASE : ebase_i;

  always_comb begin
    case (dec_i.ofs)
      OFS_INTR:   ofs = iv_i  ? ADDR_W'(OFS_IVEC) : '0;
      OFS_REFILL: ofs = exl_i ? ADDR_W'(OFS_GEN)  : '0;
      default:    ofs = ADDR_W'(OFS_GEN);
    endcase
  end

  assign pc_o = dec_i.to_reset ? RESET_PC : base + ofs;
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_entry_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                VPN_W     = 21,
  parameter int                COP_W     = 2,
  parameter logic [ADDR_W-1:0] EBASE_RST = 32'h8000_0000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  exc_dec_t            dec_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic [ADDR_W-1:0]   bad_addr_i,
  input  logic [VPN_W-3:0]    vpn2_i,
  input  logic [COP_W-1:0]    cop_id_i,
  input  logic                eret_i,
  input  logic                cfg_we_i,
  input  logic                cfg_bev_i,
  input  logic                cfg_iv_i,
  input  logic [ADDR_W-1:0]   cfg_ebase_i,
  output logic                redirect_o,
  output logic [ADDR_W-1:0]   redirect_pc_o,
  output logic                unimpl_o,
  output logic [CODE_W-1:0]   exc_code_o,
  output logic [COP_W-1:0]    cause_ce_o,
  output logic                cause_iv_o,
  output logic [ADDR_W-1:0]   bad_vaddr_o,
  output logic [VPN_W-3:0]    ctx_badvpn2_o,
  output logic                status_exl_o,
  output logic                status_bev_o,
  output logic                status_cu1_o,
  output logic [ADDR_W-1:0]   ebase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
      unimpl_o      <= 1'b0;
      exc_code_o    <= '0;
      cause_ce_o    <= '0;
      cause_iv_o    <= 1'b0;
      bad_vaddr_o   <= '0;
      ctx_badvpn2_o <= '0;
      status_exl_o  <= 1'b0;
      status_bev_o  <= 1'b1;
      status_cu1_o  <= 1'b0;
      ebase_o       <= EBASE_RST;
    end else begin
      redirect_o <= dec_i.taken | dec_i.to_reset;
      unimpl_o   <= dec_i.unimpl;
      if (dec_i.taken | dec_i.to_reset) redirect_pc_o <= pc_i;
      if (dec_i.to_reset) status_cu1_o <= 1'b1;
      if (dec_i.taken) begin
        status_exl_o <= 1'b1;
        exc_code_o   <= dec_i.code;
      end else if (eret_i) begin
        status_exl_o <= 1'b0;
      end
      if (dec_i.taken && dec_i.wr_bad) bad_vaddr_o   <= bad_addr_i;
      if (dec_i.taken && dec_i.wr_ctx) ctx_badvpn2_o <= vpn2_i;
      if (dec_i.taken && dec_i.wr_ce)  cause_ce_o    <= cop_id_i;
      if (cfg_we_i) begin
        status_bev_o <= cfg_bev_i;
        cause_iv_o   <= cfg_iv_i;
        ebase_o      <= cfg_ebase_i;
      end
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                VPN_W     = 21,
  parameter int                COP_W     = 2,
  parameter logic [ADDR_W-1:0] RESET_PC  = 32'hBFC0_0000,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 32'hBFC0_0200,
  parameter logic [ADDR_W-1:0] EBASE_RST = 32'h8000_0000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REQ-1:0]  req_i,
  input  logic                is_store_i,
  input  logic [ADDR_W-1:0]   bad_addr_i,
  input  logic [VPN_W-1:0]    vpn_i,
  input  logic [COP_W-1:0]    cop_id_i,
  input  logic                eret_i,
  input  logic                cfg_we_i,
  input  logic                cfg_bev_i,
  input  logic                cfg_iv_i,
  input  logic [ADDR_W-1:0]   cfg_ebase_i,
  output logic                redirect_o,
  output logic [ADDR_W-1:0]   redirect_pc_o,
  output logic                unimpl_o,
  output logic [CODE_W-1:0]   exc_code_o,
  output logic [COP_W-1:0]    cause_ce_o,
  output logic                cause_iv_o,
  output logic [ADDR_W-1:0]   bad_vaddr_o,
  output logic [VPN_W-3:0]    ctx_badvpn2_o,
  output logic                status_exl_o,
  output logic                status_bev_o,
  output logic                status_cu1_o,
  output logic [ADDR_W-1:0]   ebase_o
);
  logic [NUM_REQ-1:0]   grant;
  logic [REQ_IDX_W-1:0] win_idx;
  logic                 win_any;
  exc_dec_t             dec;
  logic [ADDR_W-1:0]    tgt_pc;
  logic                 vpn_lsb_unused;

  assign vpn_lsb_unused = ^{vpn_i[1:0], grant};

  exc_prio_sel #(.N(NUM_REQ), .IW(REQ_IDX_W)) u_sel (
    .req_i   (req_i),
    .grant_o (grant),
    .idx_o   (win_idx),
    .any_o   (win_any)
  );

  exc_decode u_dec (
    .idx_i      (win_idx),
    .any_i      (win_any),
    .is_store_i (is_store_i),
    .dec_o      (dec)
  );

  exc_target #(
    .ADDR_W    (ADDR_W),
    .RESET_PC  (RESET_PC),
    .BOOT_BASE (BOOT_BASE)
  ) u_tgt (
    .dec_i   (dec),
    .bev_i   (status_bev_o),
    .iv_i    (cause_iv_o),
    .exl_i   (status_exl_o),
    .ebase_i (ebase_o),
    .pc_o    (tgt_pc)
  );

  exc_state_regs #(
    .ADDR_W    (ADDR_W),
    .VPN_W     (VPN_W),
    .COP_W     (COP_W),
    .EBASE_RST (EBASE_RST)
  ) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .dec_i         (dec),
    .pc_i          (tgt_pc),
    .bad_addr_i    (bad_addr_i),
    .vpn2_i        (vpn_i[VPN_W-1:2]),
    .cop_id_i      (cop_id_i),
    .eret_i        (eret_i),
    .cfg_we_i      (cfg_we_i),
    .cfg_bev_i     (cfg_bev_i),
    .cfg_iv_i      (cfg_iv_i),
    .cfg_ebase_i   (cfg_ebase_i),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .unimpl_o      (unimpl_o),
    .exc_code_o    (exc_code_o),
    .cause_ce_o    (cause_ce_o),
    .cause_iv_o    (cause_iv_o),
    .bad_vaddr_o   (bad_vaddr_o),
    .ctx_badvpn2_o (ctx_badvpn2_o),
    .status_exl_o  (status_exl_o),
    .status_bev_o  (status_bev_o),
    .status_cu1_o  (status_cu1_o),
    .ebase_o       (ebase_o)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'hBFC0_0000
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_REQ-1:0]  req_i,
  input logic                redirect_o,
  input logic [ADDR_W-1:0]   redirect_pc_o,
  input logic                unimpl_o,
  input logic [CODE_W-1:0]   exc_code_o,
  input logic                status_exl_o,
  input logic                status_bev_o,
  input logic                status_cu1_o
);
  localparam logic [NUM_REQ-1:0] ONE = NUM_REQ'(1);

  assert_reset_vec_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[F_RESET] |=> redirect_o && redirect_pc_o == RESET_PC && status_cu1_o);

  assert_unimpl_noredir_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i[F_RESET] && (req_i[F_NMI] || req_i[F_SRST])) |=> !redirect_o && unimpl_o);

  assert_exl_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i[F_SRST:F_RESET] == '0 && |req_i[NUM_REQ-1:F_MCHK]) |=> status_exl_o && redirect_o);

  assert_no_spurious_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |=> !redirect_o && !unimpl_o);

  assert_one_outcome_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(redirect_o && unimpl_o));

  assert_tlbmod_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == (ONE << F_TLB_MOD)) |=> exc_code_o == EC_MOD);

  assert_boot_base_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_bev_o && req_i == (ONE << F_SYSCALL)) |=> redirect_pc_o == 32'hBFC0_0380);
endmodule

bind exc_entry_unit exc_entry_chk #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .unimpl_o      (unimpl_o),
  .exc_code_o    (exc_code_o),
  .status_exl_o  (status_exl_o),
  .status_bev_o  (status_bev_o),
  .status_cu1_o  (status_cu1_o)
);

// File: tb/exc_entry_unit_tb_top.sv
module exc_entry_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 15;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NR-1:0] req_i = '0;
  logic          is_store_i = 1'b0;
  logic [31:0]   bad_addr_i = '0;
  logic [20:0]   vpn_i = '0;
  logic [1:0]    cop_id_i = '0;
  logic          eret_i = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic          cfg_bev_i = 1'b0;
  logic          cfg_iv_i = 1'b0;
  logic [31:0]   cfg_ebase_i = '0;
  logic          redirect_o;
  logic [31:0]   redirect_pc_o;
  logic          unimpl_o;
  logic [4:0]    exc_code_o;
  logic [1:0]    cause_ce_o;
  logic          cause_iv_o;
  logic [31:0]   bad_vaddr_o;
  logic [18:0]   ctx_badvpn2_o;
  logic          status_exl_o;
  logic          status_bev_o;
  logic          status_cu1_o;
  logic [31:0]   ebase_o;

  exc_entry_unit dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model state
  logic        m_exl, m_bev, m_iv, m_cu1;
  logic [31:0] m_ebase, m_bad;
  logic [4:0]  m_code;
  logic [1:0]  m_ce;
  logic [18:0] m_ctx;
  int          seq = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", what, act, exp);
    end
  endtask

  function automatic logic [4:0] code_of(input int k, input logic st);
    case (k)
      3: return 5'd24;
      4: return st ? 5'd5 : 5'd4;
      5, 6: return st ? 5'd3 : 5'd2;
      7: return 5'd1;
      8: return 5'd8;
      9: return 5'd9;
      10: return 5'd10;
      11: return 5'd11;
      12: return 5'd12;
      13: return 5'd13;
      default: return 5'd0;
    endcase
  endfunction

  task automatic step(input logic [NR-1:0] r, input logic st, input logic cwe,
                      input logic cb, input logic ci, input logic [31:0] ceb,
                      input logic er, input string tag);
    int k;
    logic n_red, n_uni;
    logic [31:0] n_pc, base, ofs, addr;
    logic [20:0] vpn;
    logic [1:0]  cop;
    seq++;
    addr = 32'h1234_5000 ^ (32'(seq) * 32'h0101_0107);
    vpn  = 21'(seq * 7919);
    cop  = 2'(seq);
    k = -1;
    for (int b = NR - 1; b >= 0; b--) if (r[b]) k = b;
    n_red = 1'b0; n_uni = 1'b0; n_pc = '0;
    if (k == 0) begin
      n_red = 1'b1; n_pc = 32'hBFC0_0000; m_cu1 = 1'b1;
      if (er) m_exl = 1'b0;
    end else if (k == 1 || k == 2) begin
      n_uni = 1'b1;
      if (er) m_exl = 1'b0;
    end else if (k >= 3) begin
      base = m_bev ? 32'hBFC0_0200 : m_ebase;
      if (k == 14)     ofs = m_iv ? 32'h200 : 32'h0;
      else if (k == 5) ofs = m_exl ? 32'h180 : 32'h0;
      else             ofs = 32'h180;
      n_pc = base + ofs; n_red = 1'b1;
      m_code = code_of(k, st);
      m_exl = 1'b1;
      if (k >= 4 && k <= 7) m_bad = addr;
      if (k >= 5 && k <= 7) m_ctx = vpn[20:2];
      if (k == 11) m_ce = cop;
    end else if (er) begin
      m_exl = 1'b0;
    end
    if (cwe) begin m_bev = cb; m_iv = ci; m_ebase = ceb; end
    req_i = r; is_store_i = st; bad_addr_i = addr; vpn_i = vpn; cop_id_i = cop;
    cfg_we_i = cwe; cfg_bev_i = cb; cfg_iv_i = ci; cfg_ebase_i = ceb; eret_i = er;
    @(negedge clk_i);
    chk({tag, " redirect R6"}, 32'(redirect_o), 32'(n_red));
    if (n_red) chk({tag, " handler pc R4 R5 R11"}, redirect_pc_o, n_pc);
    chk({tag, " unimpl R12"}, 32'(unimpl_o), 32'(n_uni));
    chk({tag, " code R3 R7"}, 32'(exc_code_o), 32'(m_code));
    chk({tag, " exl R7"}, 32'(status_exl_o), 32'(m_exl));
    chk({tag, " badvaddr R8"}, bad_vaddr_o, m_bad);
    chk({tag, " context R9"}, 32'(ctx_badvpn2_o), 32'(m_ctx));
    chk({tag, " cause ce R10"}, 32'(cause_ce_o), 32'(m_ce));
    chk({tag, " cu1 R11"}, 32'(status_cu1_o), 32'(m_cu1));
    chk({tag, " cfg R13"}, {ebase_o[31:2], status_bev_o, cause_iv_o},
        {m_ebase[31:2], m_bev, m_iv});
  endtask

  task automatic idle(input string tag);
    step('0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("reset exl R1", 32'(status_exl_o), 0);
    chk("reset bev R1", 32'(status_bev_o), 1);
    chk("reset iv R1", 32'(cause_iv_o), 0);
    chk("reset ebase R1", ebase_o, 32'h8000_0000);
    chk("reset cu1 R1", 32'(status_cu1_o), 0);
    chk("reset code R1", 32'(exc_code_o), 0);
    chk("reset ce R1", 32'(cause_ce_o), 0);
    chk("reset badvaddr R1", bad_vaddr_o, 0);
    chk("reset ctx R1", 32'(ctx_badvpn2_o), 0);
    chk("reset redirect R1", 32'(redirect_o), 0);
    chk("reset unimpl R1", 32'(unimpl_o), 0);
    m_exl = 0; m_bev = 1; m_iv = 0; m_cu1 = 0; m_ebase = 32'h8000_0000;
    m_bad = 0; m_code = 0; m_ce = 0; m_ctx = 0;
    rst_ni = 1'b1;
    idle("post-reset R1");

    // single request lines under every BEV/IV/EXL/store combination
    for (int k = 0; k < NR; k++) begin
      for (int c = 0; c < 16; c++) begin
        step('0, 1'b0, 1'b1, c[0], c[1], c[3] ? 32'h9000_1000 : 32'h8000_0000,
             1'b1, "setup R13");
        if (c[2]) step(NR'(1) << 8, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "exl-set R7");
        step(NR'(1) << k, c[3], 1'b0, 1'b0, 1'b0, 0, 1'b0, "single R3 R5");
        idle("pulse-end R6");
      end
    end

    // every pair of request lines
    for (int i = 0; i < NR; i++) begin
      for (int j = i + 1; j < NR; j++) begin
        step((NR'(1) << i) | (NR'(1) << j), j[0], 1'b0, 1'b0, 1'b0, 0, 1'b1, "pair R2");
        idle("pair-idle R2");
      end
    end

    // config write and eret at the same edge as a fault
    step('0, 1'b0, 1'b1, 1'b0, 1'b1, 32'hA000_0000, 1'b1, "cfg R13");
    step(NR'(1) << 14, 1'b0, 1'b1, 1'b1, 1'b0, 32'hC000_0000, 1'b1, "same-edge R13");
    step(NR'(1) << 5, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b1, "refill-exl R5");

    // pseudo-random vectors, back to back
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(NR'(lfsr[14:0] & (lfsr[3] ? 15'h7FFF : 15'h7FF8)) >> lfsr[7:5],
           lfsr[1], lfsr[9] & lfsr[2], lfsr[11], lfsr[4],
           {lfsr, lfsr} & 32'hFFFF_F000, lfsr[6], "random R2 R8 R9 R10");
    end
    idle("final R6");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule